// File: doc/BRIEF.md
# Pipelined Unrounded Single-Precision Multiplier

This block multiplies two single-precision binary floating-point operands and returns the exact product without rounding. It yields the product sign, a widened biased exponent and the full 48-bit significand product with its leading one held at the top bit. A later stage can then round the wide significand, or use all of it. One example is the adder of a multiply-accumulate path.

The datapath is a fixed three-stage pipeline. A valid bit travels beside each operand pair, and a new pair may be issued on every clock. Only normalized operands are accepted. Two flags report whether the result exponent has left the normal range, either above it or below it.

Top module: `fmul_unrounded`

## Requirements
- R1: Each operand word holds the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. The block is defined only for exponent fields from 1 to 254.
- R2: `out_sign` is the exclusive OR of bit 31 of the two operands.
- R3: `out_exp` is the 10-bit two's complement value of ea + eb - 127 + n. Here ea and eb are the operand exponent fields, and n is 1 when the raw 48-bit product of the significands has bit 47 set, and 0 otherwise.
- R4: Each significand is formed by placing a 1 above the 23-bit fraction. `out_sig` is the exact 48-bit product of the two significands when its bit 47 is set. Otherwise it is that product shifted left by one place, with 0 in bit 0. In both cases `out_sig[47]` is 1 on every valid result.
- R5: `out_ovf` is 1 exactly when `out_exp`, read as signed, is 255 or more.
- R6: `out_unf` is 1 exactly when `out_exp`, read as signed, is 0 or less.
- R7: A result leaves the block with `out_valid` high three clocks after its operands were taken with `in_valid` high. `out_valid` stays low in every other cycle.
- R8: `rst` is synchronous and active high. It clears all three valid bits. Operands in flight at that edge, and operands presented with it, never appear at the output.
- R9: Operand pairs may arrive on consecutive clocks, and each result depends only on its own pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 10 | Biased result exponent, two's complement |
| out_sig | output | 48 | Unrounded normalized significand product |
| out_ovf | output | 1 | Exponent at or above 255 |
| out_unf | output | 1 | Exponent at or below 0 |

## Verification
The bench builds the block with its default single-precision widths, an 8-bit exponent and a 23-bit fraction. At these widths a bench can compute the full 48-bit product exactly in 64-bit integers. Directed pairs are placed on the edges of the exponent range: 254 and 255 on either side of the 48-bit carry, and 0 and 1 likewise. Biased random runs push the exponent sums into both flag regions. Random bubbles and a reset in mid-stream test the valid pipeline.

// File: rtl/fmul_unrounded.sv
module fmul_unrounded #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      out_valid,
  output logic                      out_sign,
  output logic [EXP_W+1:0]          out_exp,
  output logic [2*FRAC_W+1:0]       out_sig,
  output logic                      out_ovf,
  output logic                      out_unf
);
  localparam int SW   = FRAC_W + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;

  // stage 1: capture, sign, exponent sum
  logic              v1, sg1;
  logic [XW-1:0]     ex1;
  logic [SW-1:0]     ma1, mb1;

  wire [EXP_W-1:0] ea = op_a[FRAC_W +: EXP_W];
  wire [EXP_W-1:0] eb = op_b[FRAC_W +: EXP_W];

  always_ff @(posedge clk) begin
    v1  <= rst ? 1'b0 : in_valid;
    sg1 <= op_a[EXP_W+FRAC_W] ^ op_b[EXP_W+FRAC_W];
    ex1 <= XW'(ea) + XW'(eb) - XW'(BIAS);
    ma1 <= {1'b1, op_a[FRAC_W-1:0]};
    mb1 <= {1'b1, op_b[FRAC_W-1:0]};
  end

  // stage 2: significand product
  logic          v2, sg2;
  logic [XW-1:0] ex2;
  logic [PW-1:0] pr2;

  always_ff @(posedge clk) begin
    v2  <= rst ? 1'b0 : v1;
    sg2 <= sg1;
    ex2 <= ex1;
    pr2 <= PW'(ma1) * PW'(mb1);
  end

  // stage 3: normalize and flag
  wire          carry = pr2[PW-1];
  wire [PW-1:0] norm  = carry ? pr2 : (pr2 << 1);
  wire [XW-1:0] adj   = ex2 + XW'(carry);
  wire          ovf_n = $signed(adj) >= $signed(XW'(EMAX));
  wire          unf_n = adj[XW-1] || (adj == '0);

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : v2;
    out_sign  <= sg2;
    out_exp   <= adj;
    out_sig   <= norm;
    out_ovf   <= ovf_n;
    out_unf   <= unf_n;
  end
endmodule

// File: rtl/fmul_unrounded_chk.sv
module fmul_unrounded_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic                  out_sign,
  input logic [EXP_W+1:0]      out_exp,
  input logic [2*FRAC_W+1:0]   out_sig,
  input logic                  out_ovf,
  input logic                  out_unf
);
  localparam int SB   = EXP_W + FRAC_W;
  localparam int EMAX = (1 << EXP_W) - 1;

  logic [1:0] since_rst;
  always_ff @(posedge clk)
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |-> (out_sign == ($past(op_a[SB], 3) ^ $past(op_b[SB], 3))));

  p_lead_one_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sig[2*FRAC_W+1]);

  p_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ovf == ($signed(out_exp) >= $signed((EXP_W+2)'(EMAX)))));

  p_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_unf == ($signed(out_exp) <= 0)));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_unf));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind fmul_unrounded fmul_unrounded_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
  .out_sig(out_sig), .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/fmul_unrounded_test.sv
module fmul_unrounded_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 40000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, out_sign, out_ovf, out_unf;
  logic [9:0]  out_exp;
  logic [47:0] out_sig;

  fmul_unrounded uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_sig(out_sig), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        sign;
    logic [9:0]  e;
    logic [47:0] sig;
    logic        ovf, unf;
  } res_t;

  res_t q[$];
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, expv);
    end
  endtask

  function automatic res_t model(input logic [31:0] a, input logic [31:0] b, input int due);
    res_t r;
    longint p;
    int e;
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = int'(a[30:23]) + int'(b[30:23]) - 127 + (p[47] ? 1 : 0);
    r.due  = due;
    r.sign = a[31] ^ b[31];
    r.e    = e[9:0];
    r.sig  = p[47] ? p[47:0] : {p[46:0], 1'b0};
    r.ovf  = (e >= 255);
    r.unf  = (e <= 0);
    return r;
  endfunction

  function automatic logic [31:0] mk(input bit s, input int e, input logic [22:0] f);
    return {s, e[7:0], f};
  endfunction

  task automatic compare();
    if (cyc == 0) return;
    if (q.size() > 0 && q[0].due == cyc) begin
      res_t x = q.pop_front();
      chk(out_valid === 1'b1, "R7 result valid three clocks late", 64'(out_valid), 64'd1);
      if (out_valid === 1'b1) begin
        chk(out_sign === x.sign, "R2 sign", 64'(out_sign), 64'(x.sign));
        chk(out_exp === x.e, "R3 exponent (R1 field layout)", 64'(out_exp), 64'(x.e));
        chk(out_sig === x.sig, "R4 significand", 64'(out_sig), 64'(x.sig));
        chk(out_ovf === x.ovf, "R5 overflow flag", 64'(out_ovf), 64'(x.ovf));
        chk(out_unf === x.unf, "R6 underflow flag", 64'(out_unf), 64'(x.unf));
      end
    end else
      chk(out_valid === 1'b0, "R7 R8 no stray out_valid", 64'(out_valid), 64'd0);
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b, input bit r);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; op_a = a; op_b = b;
    if (r) q.delete();
    else if (v) q.push_back(model(a, b, cyc + 3));
  endtask

  task automatic rand_run(input int n, input int elo, input int ehi);
    for (int i = 0; i < n; i++) begin
      int e1 = elo + int'($urandom % 32'(ehi - elo + 1));
      int e2 = elo + int'($urandom % 32'(ehi - elo + 1));
      step(($urandom % 4) != 0, mk($urandom % 2, e1, 23'($urandom)),
           mk($urandom % 2, e2, 23'($urandom)), 1'b0);
    end
  endtask

  bit done = 0;

  initial begin
    // R8: valid inputs during reset must never surface
    for (int i = 0; i < 4; i++) step(1'b1, 32'h3F80_0000, 32'h3F80_0000, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b0);
    // R2 R3 R4: unity, sign mix, carry case
    step(1'b1, 32'h3F80_0000, 32'h3F80_0000, 1'b0);
    step(1'b1, mk(1, 127, 23'h40_0000), mk(0, 128, 0), 1'b0);
    step(1'b1, mk(0, 127, 23'h40_0000), mk(1, 127, 23'h40_0000), 1'b0);
    step(1'b1, mk(1, 130, 23'h7F_FFFF), mk(1, 120, 23'h7F_FFFF), 1'b0);
    // R5 boundaries: 254 without carry, 255 with carry, 255 without carry
    step(1'b1, mk(0, 254, 0), mk(0, 127, 0), 1'b0);
    step(1'b1, mk(0, 254, 23'h40_0000), mk(0, 127, 23'h40_0000), 1'b0);
    step(1'b1, mk(0, 254, 0), mk(0, 128, 0), 1'b0);
    step(1'b1, mk(0, 254, 23'h7F_FFFF), mk(1, 254, 23'h7F_FFFF), 1'b0);
    // R6 boundaries: 0 without carry, 1 with carry, 1 without, minimum
    step(1'b1, mk(0, 1, 0), mk(0, 126, 0), 1'b0);
    step(1'b1, mk(0, 1, 23'h40_0000), mk(0, 126, 23'h40_0000), 1'b0);
    step(1'b1, mk(0, 1, 0), mk(0, 127, 0), 1'b0);
    step(1'b1, mk(1, 1, 0), mk(0, 1, 0), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b0);
    // R8: reset in mid-stream drops in-flight results
    for (int i = 0; i < 3; i++) step(1'b1, mk(0, 127 + i, 23'h12_3456), mk(0, 127, 0), 1'b0);
    step(1'b1, 32'h4000_0000, 32'h4000_0000, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, '0, '0, 1'b0);
    // R9: back-to-back stream with bubbles; full range and both flag regions
    rand_run(3000, 1, 254);
    rand_run(1500, 180, 254);
    rand_run(1500, 1, 70);
    for (int i = 0; i < 5; i++) step(1'b1, mk(i % 2, 100 + i, 23'($urandom)), mk(0, 60 + i, 23'($urandom)), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, '0, '0, 1'b0);
    chk(q.size() == 0, "R7 all results delivered", 64'(q.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule